// File: doc/BRIEF.md
# Look-ahead Row Opener for a Multi-Bank DRAM Scheduler

This block manages the row latches of a banked DRAM on behalf of a scheduler that favours row hits. Each time the scheduler hands over a request whose column burst is starting, the block inspects the request that will most likely be served next. That is the new head of the queue the current request came from. When that head cannot be used, it is the head of the opposite queue. If that upcoming request needs a row that is not latched in a bank other than the one now transferring data, the block opens that row during the burst. When the bank holds a different row, it first closes it and then activates the needed row. The activation latency is therefore hidden behind the data transfer of the current access.

Banks are closed only when a known upcoming access needs another row in them. A bank that sits idle keeps its row latched, so a later access to the same row is served as a hit. The block keeps an open flag and an open-row number for every bank. Commands go out through a simple one-command-per-cycle slot, with a fixed gap of `T_RP` cycles between a close and the following activate. While a look-ahead sequence is pending, `la_busy` is high. The scheduler must hold off the next access until it drops, which exposes any latency that does not fit within the burst.

Top module: `lazy_prefetch_ctrl`

## Requirements
- R1: A bank is never closed unless an accepted request's look-ahead requires another row in it. With no accepted request, no close command is issued and every open bank stays open with its row unchanged.
- R2: If the look-ahead target is in a bank that already holds the target row, no command is issued.
- R3: If the look-ahead target is in a closed bank, only an activate is issued, one cycle after acceptance. It carries that bank and the target row.
- R4: If the look-ahead target is in a bank that holds a different row, a close to that bank is issued one cycle after acceptance. An activate of the target row in the same bank follows exactly `T_RP` cycles after the close.
- R5: The target is the head of the opposite queue in three cases: the same-queue head is in the current bank but a different row, the current request is flagged last of its batch, or the same queue is empty. Queue select: `cur_queue` 0 means read queue, 1 means write queue.
- R6: If the same-queue head is a row hit in the current bank and the batch has not ended, no command is issued and the opposite queue is not consulted.
- R7: No close or activate ever targets the bank of the request being transferred. An opposite-queue head in that bank, or an empty opposite queue, produces no command.
- R8: An activate marks its bank open with its row, and a close marks its bank closed. An accepted request marks its own bank open with its own row.
- R9: `la_busy` is high from the cycle after an accepted request that needs commands until the cycle after its activate. A `cur_valid` pulse while `la_busy` is high is ignored and causes no command.
- R10: After reset all banks are closed, no command is asserted and `la_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_valid | input | 1 | Pulse: a request is dequeued and its column burst starts |
| cur_queue | input | 1 | Queue of the current request: 0 read, 1 write |
| cur_bank | input | BANK_W | Bank of the current request |
| cur_row | input | ROW_W | Row of the current request |
| cur_last | input | 1 | Current request ends its batch |
| rd_head_valid | input | 1 | Read queue has a head entry |
| rd_head_bank | input | BANK_W | Bank of the read queue head |
| rd_head_row | input | ROW_W | Row of the read queue head |
| wr_head_valid | input | 1 | Write queue has a head entry |
| wr_head_bank | input | BANK_W | Bank of the write queue head |
| wr_head_row | input | ROW_W | Row of the write queue head |
| cmd_pre | output | 1 | Close (precharge) command this cycle |
| cmd_act | output | 1 | Activate command this cycle |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the activate |
| la_busy | output | 1 | Look-ahead sequence pending |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| bank_row | output | NUM_BANKS*ROW_W | Per-bank open row, bank b at bits b*ROW_W upward |

## Verification
A chained table of requests walks the target choice through each of its branches, starting from reset. The cases are a same-queue hit in another bank, a closed bank, an open bank holding a different row, a same-bank conflict, a batch end, an empty same queue, and an opposite head that falls in the current bank. Each branch is told apart by whether a close and an activate appear, by their cycle offsets, and by the bank and row they carry. Because the table state carries over from one request to the next, the per-bank open rows that the table checks confirm the bookkeeping. Directed tests cover a request offered while a sequence is pending, a long idle stretch that must not close any bank, and reset in the middle of a run.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
// lpc_pkg: shared types for the look-ahead row opener.
// Assumes: nothing beyond IEEE 1800-2017.
package lpc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PRE  = 2'd1,
        SEQ_WAIT = 2'd2,
        SEQ_ACT  = 2'd3
    } seq_state_e;

    localparam logic QSEL_READ  = 1'b0;
    localparam logic QSEL_WRITE = 1'b1;
endpackage

// File: rtl/lpc_bank_table.sv
`timescale 1ns/1ps
// lpc_bank_table: per-bank open flag and open row.
// Assumes: close and activate never fall in the same cycle as a mark
// from an accepted request (the sequencer is busy whenever it commands).
module lpc_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pre_en,
    input  logic                        act_en,
    input  logic [BANK_W-1:0]           cmd_bank,
    input  logic [ROW_W-1:0]            cmd_row,
    input  logic                        mark_en,
    input  logic [BANK_W-1:0]           mark_bank,
    input  logic [ROW_W-1:0]            mark_row,
    output logic [NUM_BANKS-1:0]        open_vec,
    output logic [NUM_BANKS*ROW_W-1:0]  row_flat
);
    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    // Update one entry per bank from commands and accepted requests.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (act_en && cmd_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= cmd_row;
            end else if (pre_en && cmd_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b0;
            end else if (mark_en && mark_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= mark_row;
            end
        end
        assign row_flat[b*ROW_W +: ROW_W] = row_q[b];
    end

    assign open_vec = open_q;

    // R8: an activate leaves its bank open with the activated row
    a_r8_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> (open_q[$past(cmd_bank)] && row_q[$past(cmd_bank)] == $past(cmd_row)));

    // R8: a close leaves its bank closed
    a_r8_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> !open_q[$past(cmd_bank)]);

    // R1: a close is only ever sent to a bank that holds a row
    a_r1_pre_only_open: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> open_q[cmd_bank]);
endmodule

// File: rtl/lpc_target_select.sv
`timescale 1ns/1ps
// lpc_target_select: picks the look-ahead request and decides which
// commands it needs, from the queue heads and the bank table.
// Assumes: inputs are stable in the cycle the current request is accepted.
module lpc_target_select #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        cur_queue,
    input  logic [BANK_W-1:0]           cur_bank,
    input  logic [ROW_W-1:0]            cur_row,
    input  logic                        cur_last,
    input  logic                        rd_v,
    input  logic [BANK_W-1:0]           rd_b,
    input  logic [ROW_W-1:0]            rd_r,
    input  logic                        wr_v,
    input  logic [BANK_W-1:0]           wr_b,
    input  logic [ROW_W-1:0]            wr_r,
    input  logic [NUM_BANKS-1:0]        open_vec,
    input  logic [NUM_BANKS*ROW_W-1:0]  row_flat,
    output logic                        need_cmd,
    output logic                        need_pre,
    output logic [BANK_W-1:0]           tgt_bank,
    output logic [ROW_W-1:0]            tgt_row
);
    import lpc_pkg::*;

    logic              same_v, oth_v;
    logic [BANK_W-1:0] same_b, oth_b;
    logic [ROW_W-1:0]  same_r, oth_r;
    logic              use_other, cand_v;
    logic [ROW_W-1:0]  latched_row;

    // Route the heads into same-queue and opposite-queue views.
    always_comb begin
        if (cur_queue == QSEL_WRITE) begin
            same_v = wr_v; same_b = wr_b; same_r = wr_r;
            oth_v  = rd_v; oth_b  = rd_b; oth_r  = rd_r;
        end else begin
            same_v = rd_v; same_b = rd_b; same_r = rd_r;
            oth_v  = wr_v; oth_b  = wr_b; oth_r  = wr_r;
        end
    end

    // Choose the candidate and classify it against the bank table.
    always_comb begin
        use_other = !same_v || cur_last ||
                    (same_b == cur_bank && same_r != cur_row);
        cand_v    = 1'b0;
        tgt_bank  = same_b;
        tgt_row   = same_r;
        if (use_other) begin
            cand_v   = oth_v && (oth_b != cur_bank);
            tgt_bank = oth_b;
            tgt_row  = oth_r;
        end else begin
            cand_v   = (same_b != cur_bank);
        end
        latched_row = row_flat[tgt_bank*ROW_W +: ROW_W];
        need_cmd = cand_v && !(open_vec[tgt_bank] && latched_row == tgt_row);
        need_pre = cand_v && open_vec[tgt_bank] && latched_row != tgt_row;
    end
endmodule

// File: rtl/lpc_cmd_seq.sv
`timescale 1ns/1ps
// lpc_cmd_seq: issues an optional close and then an activate through a
// one-command-per-cycle slot, keeping T_RP cycles between the two.
// Assumes: start is only raised while idle; T_RP >= 1.
module lpc_cmd_seq #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int T_RP      = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(T_RP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_pre,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [ROW_W-1:0]  start_row,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              busy
);
    import lpc_pkg::*;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;

    // Step through close, gap and activate for one look-ahead target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
            row_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    bank_q  <= start_bank;
                    row_q   <= start_row;
                    state_q <= start_pre ? SEQ_PRE : SEQ_ACT;
                end
                SEQ_PRE: begin
                    if (T_RP > 1) begin
                        cnt_q   <= CNT_W'(T_RP - 2);
                        state_q <= SEQ_WAIT;
                    end else begin
                        state_q <= SEQ_ACT;
                    end
                end
                SEQ_WAIT: begin
                    if (cnt_q == '0) state_q <= SEQ_ACT;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign cmd_pre  = (state_q == SEQ_PRE);
    assign cmd_act  = (state_q == SEQ_ACT);
    assign cmd_bank = bank_q;
    assign cmd_row  = row_q;
    assign busy     = (state_q != SEQ_IDLE);

    // R4: a close is followed by a cycle that is still busy and not a close
    a_r4_pre_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |=> (busy && !cmd_pre));

    // R9: the sequence ends the cycle after its activate
    a_r9_act_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |=> !busy);

    // R4: the target held by the sequencer does not move while busy
    a_r4_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bank_q) && $stable(row_q)));
endmodule

// File: rtl/lazy_prefetch_ctrl.sv
`timescale 1ns/1ps
// lazy_prefetch_ctrl: look-ahead row opener for a multi-bank DRAM
// scheduler. Opens the row of the next likely request in another bank
// while the current burst runs; closes a bank only when that is needed.
// Assumes: the scheduler holds the next access while la_busy is high.
module lazy_prefetch_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int T_RP      = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cur_valid,
    input  logic                        cur_queue,
    input  logic [BANK_W-1:0]           cur_bank,
    input  logic [ROW_W-1:0]            cur_row,
    input  logic                        cur_last,
    input  logic                        rd_head_valid,
    input  logic [BANK_W-1:0]           rd_head_bank,
    input  logic [ROW_W-1:0]            rd_head_row,
    input  logic                        wr_head_valid,
    input  logic [BANK_W-1:0]           wr_head_bank,
    input  logic [ROW_W-1:0]            wr_head_row,
    output logic                        cmd_pre,
    output logic                        cmd_act,
    output logic [BANK_W-1:0]           cmd_bank,
    output logic [ROW_W-1:0]            cmd_row,
    output logic                        la_busy,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ROW_W-1:0]  bank_row
);
    logic              accept;
    logic              need_cmd, need_pre;
    logic [BANK_W-1:0] tgt_bank;
    logic [ROW_W-1:0]  tgt_row;
    logic [BANK_W-1:0] acc_bank_q;

    assign accept = cur_valid && !la_busy;

    lpc_target_select #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_sel (
        .cur_queue (cur_queue),
        .cur_bank  (cur_bank),
        .cur_row   (cur_row),
        .cur_last  (cur_last),
        .rd_v      (rd_head_valid),
        .rd_b      (rd_head_bank),
        .rd_r      (rd_head_row),
        .wr_v      (wr_head_valid),
        .wr_b      (wr_head_bank),
        .wr_r      (wr_head_row),
        .open_vec  (bank_open),
        .row_flat  (bank_row),
        .need_cmd  (need_cmd),
        .need_pre  (need_pre),
        .tgt_bank  (tgt_bank),
        .tgt_row   (tgt_row)
    );

    lpc_cmd_seq #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RP(T_RP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && need_cmd),
        .start_pre  (need_pre),
        .start_bank (tgt_bank),
        .start_row  (tgt_row),
        .cmd_pre    (cmd_pre),
        .cmd_act    (cmd_act),
        .cmd_bank   (cmd_bank),
        .cmd_row    (cmd_row),
        .busy       (la_busy)
    );

    lpc_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_en    (cmd_pre),
        .act_en    (cmd_act),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .mark_en   (accept),
        .mark_bank (cur_bank),
        .mark_row  (cur_row),
        .open_vec  (bank_open),
        .row_flat  (bank_row)
    );

    // Remember the bank of the burst in flight for the R7 check.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_bank_q <= '0;
        else if (accept) acc_bank_q <= cur_bank;
    end

    // R7: look-ahead commands never hit the bank now transferring data
    a_r7_not_current: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pre || cmd_act) |-> (cmd_bank != acc_bank_q));

    // R9: at most one command per cycle in the slot
    a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_pre && cmd_act));

    // R9: a request offered while busy does not disturb the sequence
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (la_busy && cur_valid && !cmd_act) |=> la_busy);

    // R10: reset leaves the slot empty
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!la_busy && !cmd_pre && !cmd_act && bank_open == '0));
endmodule

// File: tb/lazy_prefetch_ctrl_tb.sv
`timescale 1ns/1ps
module lazy_prefetch_ctrl_tb;
    localparam int NB   = 4;
    localparam int RW   = 12;
    localparam int TRP  = 2;
    localparam int NVEC = 10;

    typedef struct packed {
        logic        q;  logic [1:0] cb; logic [11:0] cr; logic last;
        logic        rv; logic [1:0] rb; logic [11:0] rr;
        logic        wv; logic [1:0] wb; logic [11:0] wr;
        logic        ep; logic ea; logic [1:0] eb; logic [11:0] er;
    } vec_t;

    // Chained vectors: bank state carries from one entry to the next.
    localparam vec_t VECS [NVEC] = '{
        // R3: same queue, other bank, closed -> activate b1 r7
        '{1'b0, 2'd0, 12'd5, 1'b0, 1'b1, 2'd1, 12'd7, 1'b0, 2'd0, 12'd0, 1'b0, 1'b1, 2'd1, 12'd7},
        // R6: same bank same row hit -> nothing, write head unused
        '{1'b0, 2'd1, 12'd7, 1'b0, 1'b1, 2'd1, 12'd7, 1'b1, 2'd2, 12'd3, 1'b0, 1'b0, 2'd0, 12'd0},
        // R5: same-bank conflict -> write head b2 r3 closed
        '{1'b0, 2'd1, 12'd7, 1'b0, 1'b1, 2'd1, 12'd9, 1'b1, 2'd2, 12'd3, 1'b0, 1'b1, 2'd2, 12'd3},
        // R5 R4: batch end -> read head b0 r6, b0 holds r5
        '{1'b1, 2'd2, 12'd3, 1'b1, 1'b1, 2'd0, 12'd6, 1'b1, 2'd3, 12'd1, 1'b1, 1'b1, 2'd0, 12'd6},
        // R2: other bank already holds the row
        '{1'b0, 2'd0, 12'd6, 1'b0, 1'b1, 2'd1, 12'd7, 1'b0, 2'd0, 12'd0, 1'b0, 1'b0, 2'd0, 12'd0},
        // R4: b2 holds r3, needs r4
        '{1'b0, 2'd0, 12'd6, 1'b0, 1'b1, 2'd2, 12'd4, 1'b0, 2'd0, 12'd0, 1'b1, 1'b1, 2'd2, 12'd4},
        // R5: same queue empty -> read head b3 closed
        '{1'b1, 2'd2, 12'd4, 1'b0, 1'b1, 2'd3, 12'd2, 1'b0, 2'd0, 12'd0, 1'b0, 1'b1, 2'd3, 12'd2},
        // R7: opposite head in current bank -> nothing
        '{1'b0, 2'd3, 12'd2, 1'b0, 1'b1, 2'd3, 12'd8, 1'b1, 2'd3, 12'd8, 1'b0, 1'b0, 2'd0, 12'd0},
        // R7: batch end with empty opposite queue -> nothing
        '{1'b0, 2'd3, 12'd2, 1'b1, 1'b1, 2'd1, 12'd0, 1'b0, 2'd0, 12'd0, 1'b0, 1'b0, 2'd0, 12'd0},
        // R8: current request remarks b1 with r0; write hit -> nothing
        '{1'b1, 2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 12'd0, 1'b1, 2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 12'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cur_valid, cur_queue, cur_last;
    logic [1:0]      cur_bank;
    logic [RW-1:0]   cur_row;
    logic            rd_head_valid, wr_head_valid;
    logic [1:0]      rd_head_bank, wr_head_bank;
    logic [RW-1:0]   rd_head_row, wr_head_row;
    logic            cmd_pre, cmd_act, la_busy;
    logic [1:0]      cmd_bank;
    logic [RW-1:0]   cmd_row;
    logic [NB-1:0]   bank_open;
    logic [NB*RW-1:0] bank_row;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lazy_prefetch_ctrl #(.NUM_BANKS(NB), .ROW_W(RW), .T_RP(TRP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cur_valid(cur_valid), .cur_queue(cur_queue), .cur_bank(cur_bank),
        .cur_row(cur_row), .cur_last(cur_last),
        .rd_head_valid(rd_head_valid), .rd_head_bank(rd_head_bank), .rd_head_row(rd_head_row),
        .wr_head_valid(wr_head_valid), .wr_head_bank(wr_head_bank), .wr_head_row(wr_head_row),
        .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .la_busy(la_busy), .bank_open(bank_open), .bank_row(bank_row)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cur_valid = 1'b1; cur_queue = v.q; cur_bank = v.cb; cur_row = v.cr;
        cur_last = v.last;
        rd_head_valid = v.rv; rd_head_bank = v.rb; rd_head_row = v.rr;
        wr_head_valid = v.wv; wr_head_bank = v.wb; wr_head_row = v.wr;
    endtask

    // Apply one vector at a negedge and watch the command slot for 7 cycles.
    task automatic run_vec(input vec_t v, input int idx);
        int npre = 0, nact = 0, pre_c = 0, act_c = 0, pb = 0, ab = 0, ar = 0;
        drive(v);
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            if (i == 1) cur_valid = 1'b0;
            if (cmd_pre) begin npre++; pre_c = i; pb = int'(cmd_bank); end
            if (cmd_act) begin nact++; act_c = i; ab = int'(cmd_bank); ar = int'(cmd_row); end
        end
        $display("vector %0d", idx);
        check("R1/R4 close count", npre, int'(v.ep));
        check("R2/R3/R6/R7 activate count", nact, int'(v.ea));
        if (v.ep) begin
            check("R4 close cycle", pre_c, 1);
            check("R4 close bank", pb, int'(v.eb));
        end
        if (v.ea) begin
            check("R3/R4 activate cycle", act_c, v.ep ? 1 + TRP : 1);
            check("R3/R5 activate bank", ab, int'(v.eb));
            check("R3/R5 activate row", ar, int'(v.er));
            check("R8 row latched", int'(bank_row[int'(v.eb)*RW +: RW]), int'(v.er));
        end
        check("R9 idle after sequence", int'(la_busy), 0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cur_valid = 1'b0; cur_queue = 1'b0; cur_bank = '0; cur_row = '0;
        cur_last = 1'b0; rd_head_valid = 1'b0; rd_head_bank = '0; rd_head_row = '0;
        wr_head_valid = 1'b0; wr_head_bank = '0; wr_head_row = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 banks closed", int'(bank_open), 0);
        check("R10 no command", int'(cmd_pre) + int'(cmd_act), 0);
        check("R10 not busy", int'(la_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

        // R8: whole table after the chain: b0 r6, b1 r0, b2 r4, b3 r2
        check("R8 all open", int'(bank_open), 15);
        check("R8 bank0 row", int'(bank_row[0*RW +: RW]), 6);
        check("R8 bank1 row", int'(bank_row[1*RW +: RW]), 0);
        check("R8 bank2 row", int'(bank_row[2*RW +: RW]), 4);
        check("R8 bank3 row", int'(bank_row[3*RW +: RW]), 2);

        // R9: second request while busy is ignored
        begin
            int npre = 0, nact = 0;
            drive('{1'b0, 2'd0, 12'd6, 1'b0, 1'b1, 2'd1, 12'd5, 1'b0, 2'd0, 12'd0,
                   1'b1, 1'b1, 2'd1, 12'd5});
            for (int i = 1; i <= 8; i++) begin
                @(negedge clk);
                if (i == 1) begin
                    // would close b2 (holds r4) if it were taken
                    cur_bank = 2'd3; cur_row = 12'd2; rd_head_bank = 2'd2; rd_head_row = 12'd9;
                end
                if (i == 2) cur_valid = 1'b0;
                if (i <= 3) check("R9 busy during sequence", int'(la_busy), 1);
                if (i == 4) check("R9 busy drops after activate", int'(la_busy), 0);
                if (cmd_pre) npre++;
                if (cmd_act) nact++;
            end
            check("R9 one close only", npre, 1);
            check("R9 one activate only", nact, 1);
            check("R9 bank2 row untouched", int'(bank_row[2*RW +: RW]), 4);
            check("R9 bank1 reopened", int'(bank_row[1*RW +: RW]), 5);
        end

        // R1: long idle stretch closes nothing
        begin
            int npre = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (cmd_pre) npre++;
            end
            check("R1 no close while idle", npre, 0);
            check("R1 banks still open", int'(bank_open), 15);
            check("R1 bank0 row kept", int'(bank_row[0*RW +: RW]), 6);
        end

        // R10: reset in mid run
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears banks", int'(bank_open), 0);
        check("R10 reset idle", int'(la_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule